// File: doc/BRIEF.md
# Error-Correcting SRAM Bus Controller

This block is the controller of a single-port on-chip RAM. Every 32-bit word is stored with 7 check bits. It serves a pipelined bus slave port that has a separate address phase and data phase. On a write it computes the check bits. On a read it checks the stored word and corrects it before returning the data. Each access type has its own fixed number of wait states. Full-word writes are posted into a one-entry buffer and complete at once. A read takes three wait states. A byte or halfword write takes four, because it is done as read, correct, merge, re-encode and write back.

When protection is on, a word that cannot be corrected ends its transfer with an error response, and each corrected single error raises a one-cycle event pulse. Two diagnostic controls act on the check bits. The first replaces the computed check bits of every write with a supplied value. The second exposes the raw check bits of each word that is read. The RAM array itself sits outside the block, behind a simple synchronous port with one cycle of read latency.

Top module: `edac_sram_ctrl`

## Requirements
- R1: With `prot_en` high, a single flipped bit anywhere in the 39 stored bits (data bits 0..31 or check bits 32..38 of the RAM word) is corrected, and the read returns the original data with an OKAY response.
- R2: With `prot_en` high, two flipped bits in a stored word make the read end with an error response.
- R3: After a read is accepted, `bus_ready` is low for exactly 3 data-phase cycles and high in the 4th, when `bus_rdata` is valid.
- R4: A full-word write (`bus_size` 2 or 3) completes with `bus_ready` high in its first data-phase cycle. The word reaches the RAM afterwards. A read accepted in that same cycle to the same address returns the new data.
- R5: A sub-word write keeps `bus_ready` low for 4 data-phase cycles. `bus_size` 0 writes the byte lane selected by address bits [1:0]. `bus_size` 1 writes lanes 1..0 when address bit 1 is 0 and lanes 3..2 when it is 1. The lanes are taken from `bus_wdata`. Every other lane keeps its corrected old value, and the whole word is re-encoded.
- R6: An error response lasts two cycles: first `bus_ready` low with `bus_err` high, then `bus_ready` high with `bus_err` high. An uncorrectable sub-word write leaves the RAM word unchanged.
- R7: `sec_pulse` is high for one cycle, in the 3rd data-phase cycle, whenever a read or the read phase of a sub-word write corrects a single error.
- R8: With `prot_en` low, the stored data is returned as it is, with no correction, no error response and no `sec_pulse`.
- R9: With `wr_bypass` high, the check bits written to RAM (RAM word bits 38..32) equal `bypass_chk`.
- R10: With `rd_bypass` high, every RAM read pulses `rd_chk_valid` in the 3rd data-phase cycle, and `rd_chk` then holds the raw stored check bits.
- R11: In and right after reset, `bus_ready` is high, and `bus_err`, `sec_pulse` and `ram_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Enables checking, correction and error reporting |
| wr_bypass | input | 1 | Store `bypass_chk` instead of computed check bits |
| rd_bypass | input | 1 | Expose raw check bits of each RAM read |
| bypass_chk | input | 7 | Check-bit value used when `wr_bypass` is high |
| bus_req | input | 1 | Address-phase transfer request |
| bus_write | input | 1 | Transfer direction, 1 = write |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_addr | input | RAM_AW+2 | Byte address |
| bus_wdata | input | 32 | Write data, valid during the data phase |
| bus_ready | output | 1 | Data phase completes when high |
| bus_err | output | 1 | Error response |
| bus_rdata | output | 32 | Read data |
| sec_pulse | output | 1 | One-cycle corrected-error event |
| rd_chk_valid | output | 1 | Raw check bits valid pulse |
| rd_chk | output | 7 | Raw check bits of the last RAM read |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | 39 | RAM write word, check bits in 38..32 |
| ram_rdata | input | 39 | RAM read word, one cycle after the read enable |

## Verification
Counting from the clock edge that accepts the address, a read completes in the 4th data-phase cycle, a full-word write in the 1st and a sub-word write in the 5th. The correction pulse and the raw check-bit pulse both fall in the 3rd cycle. The two error-response cycles are the last two of the transfer. The bench drives and samples on falling edges. It numbers each data-phase cycle from 1 and records in which numbered cycle every pulse, error flag and ready level appears, then compares those cycle numbers with the ones above. RAM contents are compared only after at least two idle cycles, so that the posted buffer has drained.

// File: rtl/edac_pkg.sv
package edac_pkg;

    localparam int DATA_W   = 32;
    localparam int HPOS_W   = 6;
    localparam int CHK_W    = HPOS_W + 1;
    localparam int LAST_POS = DATA_W + HPOS_W;
    localparam int LANES    = DATA_W / 8;

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } cword_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              single;
        logic              uncorr;
    } dec_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_CHECK,
        ST_RD_HOLD,
        ST_RD_DONE,
        ST_MW_ISSUE,
        ST_MW_CHECK,
        ST_MW_STORE,
        ST_MW_HOLD,
        ST_MW_DONE
    } state_t;

    // Hamming position (non power of two) assigned to data bit idx
    function automatic logic [HPOS_W-1:0] hpos(input int idx);
        int n;
        logic [HPOS_W-1:0] r;
        n = 0;
        r = '0;
        for (int p = 3; p <= LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) r = HPOS_W'(p);
                n = n + 1;
            end
        end
        return r;
    endfunction

    function automatic logic [HPOS_W-1:0] hsyn(input logic [DATA_W-1:0] d);
        logic [HPOS_W-1:0] s;
        s = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) s = s ^ hpos(i);
        end
        return s;
    endfunction

    // Check bits 5..0 are Hamming parities, bit 6 makes total parity even
    function automatic cword_t encode(input logic [DATA_W-1:0] d);
        cword_t w;
        w.data               = d;
        w.chk[HPOS_W-1:0]    = hsyn(d);
        w.chk[HPOS_W]        = (^d) ^ (^w.chk[HPOS_W-1:0]);
        return w;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size,
                                                   input logic [1:0] lo);
        logic [LANES-1:0] m;
        case (size)
            2'd0:    m = 4'b0001 << lo;
            2'd1:    m = lo[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_d,
                                                input logic [DATA_W-1:0] new_d,
                                                input logic [LANES-1:0]  m);
        logic [DATA_W-1:0] r;
        r = old_d;
        for (int b = 0; b < LANES; b++) begin
            if (m[b]) r[b*8 +: 8] = new_d[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/edac_enc.sv
module edac_enc
    import edac_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic              byp,
    input  logic [CHK_W-1:0]  byp_chk,
    output cword_t            word
);
    always_comb begin
        word = encode(data);
        if (byp) word.chk = byp_chk;
    end
endmodule

// File: rtl/edac_dec.sv
module edac_dec
    import edac_pkg::*;
(
    input  logic   en,
    input  cword_t word,
    output dec_t   res
);
    logic [HPOS_W-1:0] syn;
    logic              par;
    logic              hit;
    logic              pow2;
    logic [DATA_W-1:0] fixed;

    always_comb begin
        syn   = hsyn(word.data) ^ word.chk[HPOS_W-1:0];
        par   = ^word;
        pow2  = (syn & (syn - 6'd1)) == 6'd0;
        hit   = 1'b0;
        fixed = word.data;
        for (int i = 0; i < DATA_W; i++) begin
            if (hpos(i) == syn) begin
                fixed[i] = ~fixed[i];
                hit      = 1'b1;
            end
        end

        res.data   = word.data;
        res.single = 1'b0;
        res.uncorr = 1'b0;
        if (en) begin
            if (!par) begin
                res.uncorr = (syn != 6'd0);
            end else if (pow2) begin
                res.single = 1'b1;
            end else if (hit) begin
                res.single = 1'b1;
                res.data   = fixed;
            end else begin
                res.uncorr = 1'b1;
            end
        end
    end

    always_comb begin
        assert_flags_excl_R2: assert (!(res.single && res.uncorr));
    end
endmodule

// File: rtl/edac_wbuf.sv
module edac_wbuf
    import edac_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill,
    input  logic [AW-1:0] fill_addr,
    input  cword_t        fill_word,
    input  logic          drain,
    input  logic [AW-1:0] look_addr,
    output logic          valid,
    output logic [AW-1:0] addr,
    output cword_t        word,
    output logic          hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            word  <= '0;
        end else if (fill) begin
            valid <= 1'b1;
            addr  <= fill_addr;
            word  <= fill_word;
        end else if (drain) begin
            valid <= 1'b0;
        end
    end

    assign hit = valid && (addr == look_addr);

    // a held word may only be replaced in the cycle it goes to the RAM
    assert_no_lost_write_R4: assert property (@(posedge clk) disable iff (rst)
        (fill && valid) |-> drain);
endmodule

// File: rtl/edac_sram_ctrl.sv
module edac_sram_ctrl
    import edac_pkg::*;
#(
    parameter int RAM_AW = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prot_en,
    input  logic                     wr_bypass,
    input  logic                     rd_bypass,
    input  logic [6:0]               bypass_chk,
    input  logic                     bus_req,
    input  logic                     bus_write,
    input  logic [1:0]               bus_size,
    input  logic [RAM_AW+1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic                     bus_ready,
    output logic                     bus_err,
    output logic [31:0]              bus_rdata,
    output logic                     sec_pulse,
    output logic                     rd_chk_valid,
    output logic [6:0]               rd_chk,
    output logic                     ram_en,
    output logic                     ram_we,
    output logic [RAM_AW-1:0]        ram_addr,
    output logic [38:0]              ram_wdata,
    input  logic [38:0]              ram_rdata
);
    localparam int BUS_AW = RAM_AW + 2;

    state_t            st, st_nx;
    logic [BUS_AW-1:0] cur_addr;
    logic [1:0]        cur_size;
    logic [RAM_AW-1:0] cur_word;
    logic              pend_wr;
    logic              accept;
    logic              is_word;
    logic              in_check;

    logic              buf_valid, buf_hit, drain;
    logic [RAM_AW-1:0] buf_addr;
    cword_t            buf_word;
    logic              fwd_q;
    cword_t            fwd_word_q;

    cword_t            word_in;
    dec_t              dec;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] enc_data;
    cword_t            enc_word;

    logic              err_q, sec_q, cbv_q;
    logic [CHK_W-1:0]  chk_q;
    logic [DATA_W-1:0] rdata_q;
    cword_t            store_q;

    assign bus_ready = (st == ST_IDLE) || (st == ST_RD_DONE) || (st == ST_MW_DONE);
    assign accept    = bus_req && bus_ready;
    assign is_word   = bus_size[1];
    assign cur_word  = cur_addr[BUS_AW-1:2];
    assign in_check  = (st == ST_RD_CHECK) || (st == ST_MW_CHECK);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_RD_DONE, ST_MW_DONE: begin
                if (!accept)          st_nx = ST_IDLE;
                else if (!bus_write)  st_nx = ST_RD_ISSUE;
                else if (is_word)     st_nx = ST_IDLE;
                else                  st_nx = ST_MW_ISSUE;
            end
            ST_RD_ISSUE: st_nx = ST_RD_CHECK;
            ST_RD_CHECK: st_nx = ST_RD_HOLD;
            ST_RD_HOLD:  st_nx = ST_RD_DONE;
            ST_MW_ISSUE: st_nx = ST_MW_CHECK;
            ST_MW_CHECK: st_nx = ST_MW_STORE;
            ST_MW_STORE: st_nx = ST_MW_HOLD;
            ST_MW_HOLD:  st_nx = ST_MW_DONE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_addr <= '0;
            cur_size <= '0;
            pend_wr  <= 1'b0;
        end else begin
            st      <= st_nx;
            pend_wr <= accept && bus_write && is_word;
            if (accept) begin
                cur_addr <= bus_addr;
                cur_size <= bus_size;
            end
        end
    end

    // write buffer and check-bit generation
    assign drain = buf_valid && !((st == ST_RD_ISSUE) || (st == ST_MW_ISSUE) ||
                                  (st == ST_MW_STORE));

    edac_wbuf #(.AW(RAM_AW)) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .fill      (pend_wr),
        .fill_addr (cur_word),
        .fill_word (enc_word),
        .drain     (drain),
        .look_addr (cur_word),
        .valid     (buf_valid),
        .addr      (buf_addr),
        .word      (buf_word),
        .hit       (buf_hit)
    );

    assign merged   = merge(dec.data, bus_wdata, lane_mask(cur_size, cur_addr[1:0]));
    assign enc_data = (st == ST_MW_CHECK) ? merged : bus_wdata;

    edac_enc u_enc (
        .data    (enc_data),
        .byp     (wr_bypass),
        .byp_chk (bypass_chk),
        .word    (enc_word)
    );

    // checking path
    assign word_in = fwd_q ? fwd_word_q : cword_t'(ram_rdata);

    edac_dec u_dec (
        .en   (prot_en),
        .word (word_in),
        .res  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q      <= 1'b0;
            fwd_word_q <= '0;
            err_q      <= 1'b0;
            sec_q      <= 1'b0;
            cbv_q      <= 1'b0;
            chk_q      <= '0;
            rdata_q    <= '0;
            store_q    <= '0;
        end else begin
            if ((st == ST_RD_ISSUE) || (st == ST_MW_ISSUE)) begin
                fwd_q      <= buf_hit;
                fwd_word_q <= buf_word;
            end
            sec_q <= in_check && dec.single;
            cbv_q <= in_check && rd_bypass;
            if (in_check) begin
                err_q <= dec.uncorr;
                if (rd_bypass) chk_q <= word_in.chk;
            end
            if (st == ST_RD_CHECK) rdata_q <= dec.data;
            if (st == ST_MW_CHECK) store_q <= enc_word;
        end
    end

    // RAM port
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = buf_addr;
        ram_wdata = buf_word;
        if ((st == ST_RD_ISSUE) || (st == ST_MW_ISSUE)) begin
            ram_en   = 1'b1;
            ram_addr = cur_word;
        end else if (st == ST_MW_STORE) begin
            ram_en    = !err_q;
            ram_we    = !err_q;
            ram_addr  = cur_word;
            ram_wdata = store_q;
        end else if (buf_valid) begin
            ram_en = 1'b1;
            ram_we = 1'b1;
        end
    end

    assign bus_err      = err_q && ((st == ST_RD_HOLD) || (st == ST_RD_DONE) ||
                                    (st == ST_MW_HOLD) || (st == ST_MW_DONE));
    assign bus_rdata    = rdata_q;
    assign sec_pulse    = sec_q;
    assign rd_chk_valid = cbv_q;
    assign rd_chk       = chk_q;

    assert_read_waits_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !bus_write) |=> !bus_ready ##1 !bus_ready ##1 !bus_ready ##1 bus_ready);

    assert_word_write_nowait_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && bus_write && is_word) |=> bus_ready);

    assert_subword_waits_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && bus_write && !is_word) |=>
            !bus_ready ##1 !bus_ready ##1 !bus_ready ##1 !bus_ready ##1 bus_ready);

    assert_err_first_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_err) |-> !bus_ready);

    assert_err_second_high_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !bus_ready) |=> (bus_err && bus_ready));

    assert_sec_in_wait_R7: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> (!bus_ready && !$past(sec_pulse)));

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!prot_en) |-> !sec_pulse);

    assert_chk_valid_src_R10: assert property (@(posedge clk) disable iff (rst)
        rd_chk_valid |-> $past(rd_bypass));
endmodule

// File: tb/sim_edac_sram_ctrl.sv
`timescale 1ns/1ps
module sim_edac_sram_ctrl;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        prot_en, wr_bypass, rd_bypass;
    logic [6:0]  bypass_chk;
    logic        bus_req, bus_write;
    logic [1:0]  bus_size;
    logic [AW+1:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ready, bus_err, sec_pulse, rd_chk_valid;
    logic [31:0] bus_rdata;
    logic [6:0]  rd_chk;
    logic        ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [38:0] ram_wdata, ram_rdata;

    logic [38:0] mem [0:(1<<AW)-1];
    logic        inj;
    logic [AW-1:0] inj_addr;
    logic [38:0] inj_mask;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int          c_waits, c_sec_n, c_sec_at, c_cbv_n;
    logic        c_err_lo, c_err_hi;
    logic [31:0] c_rdata;
    logic [6:0]  c_chk;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
        end else if (inj) begin
            mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        end
    end

    edac_sram_ctrl #(.RAM_AW(AW)) u0 (
        .clk(clk), .rst(rst), .prot_en(prot_en), .wr_bypass(wr_bypass),
        .rd_bypass(rd_bypass), .bypass_chk(bypass_chk), .bus_req(bus_req),
        .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .sec_pulse(sec_pulse), .rd_chk_valid(rd_chk_valid),
        .rd_chk(rd_chk), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at the falling edge of data-phase cycle 1
    task automatic collect();
        c_waits = 0; c_sec_n = 0; c_sec_at = 0; c_cbv_n = 0;
        c_err_lo = 1'b0; c_err_hi = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            if (k > 1) @(negedge clk);
            if (sec_pulse) begin c_sec_n++; c_sec_at = k; end
            if (rd_chk_valid) begin c_cbv_n++; c_chk = rd_chk; end
            if (bus_ready) begin
                c_err_hi = bus_err;
                c_rdata  = bus_rdata;
                break;
            end
            c_waits++;
            c_err_lo = bus_err;
        end
    endtask

    task automatic xfer(input logic wr, input logic [1:0] sz, input logic [AW+1:0] a,
                        input logic [31:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        bus_wdata = wd;
        collect();
    endtask

    task automatic wr_word(input int w, input logic [31:0] d);
        xfer(1'b1, 2'd2, (AW+2)'(w * 4), d);
        chk("R4 word write waits", 64'(c_waits), 64'd0);
        idle(3);
    endtask

    task automatic rd_word(input int w);
        xfer(1'b0, 2'd2, (AW+2)'(w * 4), 32'h0);
        chk("R3 read waits", 64'(c_waits), 64'd3);
    endtask

    task automatic inject(input int w, input logic [38:0] m);
        @(negedge clk);
        inj = 1'b1; inj_addr = AW'(w); inj_mask = m;
        @(negedge clk);
        inj = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        chk("R11 ready in reset", 64'(bus_ready), 64'd1);
        chk("R11 ram_en in reset", 64'(ram_en), 64'd0);
        rst = 1'b0;
        idle(1);
        chk("R11 ready", 64'(bus_ready), 64'd1);
        chk("R11 err", 64'(bus_err), 64'd0);
        chk("R11 sec", 64'(sec_pulse), 64'd0);
        chk("R11 ram_en", 64'(ram_en), 64'd0);
    endtask

    task automatic t_word_rw();
        logic [31:0] pats [4];
        pats[0] = 32'hDEADBEEF; pats[1] = 32'h0; pats[2] = 32'hFFFFFFFF; pats[3] = 32'h12345678;
        for (int i = 0; i < 4; i++) begin
            wr_word(i + 1, pats[i]);
            chk("R4 word in RAM", 64'(mem[i + 1][31:0]), 64'(pats[i]));
        end
        for (int i = 0; i < 4; i++) begin
            rd_word(i + 1);
            chk("R3 read data", 64'(c_rdata), 64'(pats[i]));
            chk("R3 read ok", 64'(c_err_hi), 64'd0);
            chk("R7 no sec on clean", 64'(c_sec_n), 64'd0);
        end
    endtask

    task automatic t_forward();
        wr_word(5, 32'h11111111);
        @(negedge clk);
        bus_req = 1'b1; bus_write = 1'b1; bus_size = 2'd2; bus_addr = (AW+2)'(20);
        @(negedge clk);
        chk("R4 zero-wait write", 64'(bus_ready), 64'd1);
        bus_wdata = 32'hA5A55A5A;
        bus_write = 1'b0;
        @(negedge clk);
        bus_req = 1'b0;
        collect();
        chk("R4 forwarded read data", 64'(c_rdata), 64'hA5A55A5A);
        chk("R3 forwarded read waits", 64'(c_waits), 64'd3);
        idle(3);
        chk("R4 drained to RAM", 64'(mem[5][31:0]), 64'hA5A55A5A);
    endtask

    task automatic t_single();
        int bits [5];
        bits[0] = 0; bits[1] = 7; bits[2] = 31; bits[3] = 32; bits[4] = 38;
        for (int i = 0; i < 5; i++) begin
            wr_word(10, 32'h0F0F1234);
            inject(10, 39'd1 << bits[i]);
            rd_word(10);
            chk("R1 corrected data", 64'(c_rdata), 64'h0F0F1234);
            chk("R1 okay response", 64'(c_err_hi), 64'd0);
            chk("R7 one sec pulse", 64'(c_sec_n), 64'd1);
            chk("R7 sec in cycle 3", 64'(c_sec_at), 64'd3);
        end
    endtask

    task automatic t_double();
        wr_word(11, 32'h55AA00FF);
        inject(11, (39'd1 << 3) | (39'd1 << 20));
        rd_word(11);
        chk("R2 error on double", 64'(c_err_hi), 64'd1);
        chk("R6 err in last wait", 64'(c_err_lo), 64'd1);
        chk("R7 no sec on double", 64'(c_sec_n), 64'd0);
        wr_word(11, 32'h55AA00FF);
        inject(11, (39'd1 << 1) | (39'd1 << 35));
        rd_word(11);
        chk("R2 error data+check", 64'(c_err_hi), 64'd1);
        chk("R6 err in last wait", 64'(c_err_lo), 64'd1);
    endtask

    task automatic t_sub();
        wr_word(12, 32'h44332211);
        xfer(1'b1, 2'd0, (AW+2)'(48 + 2), 32'h00AB0000);
        chk("R5 byte write waits", 64'(c_waits), 64'd4);
        chk("R5 byte write ok", 64'(c_err_hi), 64'd0);
        rd_word(12);
        chk("R5 byte lane 2", 64'(c_rdata), 64'h44AB2211);
        xfer(1'b1, 2'd1, (AW+2)'(48), 32'h0000BEEF);
        chk("R5 half write waits", 64'(c_waits), 64'd4);
        rd_word(12);
        chk("R5 low half", 64'(c_rdata), 64'h44ABBEEF);
        xfer(1'b1, 2'd0, (AW+2)'(48 + 3), 32'h7E000000);
        rd_word(12);
        chk("R5 byte lane 3", 64'(c_rdata), 64'h7EABBEEF);
        xfer(1'b1, 2'd1, (AW+2)'(48 + 2), 32'hC0DE0000);
        rd_word(12);
        chk("R5 high half", 64'(c_rdata), 64'hC0DEBEEF);
        idle(2);
        inject(12, 39'd1 << 9);
        xfer(1'b1, 2'd0, (AW+2)'(48), 32'h000000AA);
        chk("R7 sec on RMW", 64'(c_sec_n), 64'd1);
        chk("R7 RMW sec cycle 3", 64'(c_sec_at), 64'd3);
        chk("R5 RMW ok", 64'(c_err_hi), 64'd0);
        rd_word(12);
        chk("R5 corrected writeback", 64'(c_rdata), 64'hC0DEBEAA);
        chk("R5 writeback clean", 64'(c_sec_n), 64'd0);
    endtask

    task automatic t_sub_err();
        wr_word(13, 32'h01020304);
        inject(13, (39'd1 << 0) | (39'd1 << 16));
        xfer(1'b1, 2'd1, (AW+2)'(52), 32'h0000FFFF);
        chk("R5 err RMW waits", 64'(c_waits), 64'd4);
        chk("R6 RMW err low cycle", 64'(c_err_lo), 64'd1);
        chk("R6 RMW err high cycle", 64'(c_err_hi), 64'd1);
        chk("R7 no sec on uncorr", 64'(c_sec_n), 64'd0);
        idle(2);
        chk("R6 RAM unchanged", 64'(mem[13][31:0]), 64'h01030305);
    endtask

    task automatic t_disabled();
        wr_word(14, 32'h89ABCDEF);
        inject(14, 39'h110);
        prot_en = 1'b0;
        rd_word(14);
        chk("R8 raw data", 64'(c_rdata), 64'h89ABCCFF);
        chk("R8 no error", 64'(c_err_hi), 64'd0);
        chk("R8 no error early", 64'(c_err_lo), 64'd0);
        chk("R8 no sec", 64'(c_sec_n), 64'd0);
        idle(1);
        inject(14, 39'h110 ^ 39'h1);
        rd_word(14);
        chk("R8 single not fixed", 64'(c_rdata), 64'h89ABCDEE);
        chk("R8 no sec single", 64'(c_sec_n), 64'd0);
        prot_en = 1'b1;
    endtask

    task automatic t_bypass();
        wr_bypass = 1'b1; bypass_chk = 7'h55;
        wr_word(15, 32'h13579BDF);
        wr_bypass = 1'b0;
        chk("R9 bypass check bits", 64'(mem[15][38:32]), 64'h55);
        prot_en = 1'b0; rd_bypass = 1'b1;
        rd_word(15);
        chk("R10 chk valid pulse", 64'(c_cbv_n), 64'd1);
        chk("R10 raw chk", 64'(c_chk), 64'h55);
        chk("R10 data", 64'(c_rdata), 64'h13579BDF);
        idle(1);
        inject(15, 39'd1 << 33);
        rd_word(15);
        chk("R10 flipped chk", 64'(c_chk), 64'h57);
        rd_bypass = 1'b0;
        rd_word(15);
        chk("R10 no pulse when off", 64'(c_cbv_n), 64'd0);
        prot_en = 1'b1;
    endtask

    initial begin
        rst = 1'b1; prot_en = 1'b1; wr_bypass = 1'b0; rd_bypass = 1'b0;
        bypass_chk = '0; bus_req = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
        bus_addr = '0; bus_wdata = '0; inj = 1'b0; inj_addr = '0; inj_mask = '0;
        t_reset();
        t_word_rw();
        t_forward();
        t_single();
        t_double();
        t_sub();
        t_sub_err();
        t_disabled();
        t_bypass();
        idle(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule